// File: doc/BRIEF.md
# Replica-Path Adaptive Clock Governor

This block sets the frequency code for an external clock generator. It bases that code only on what it sees on a replica timing path. The replica is a copy of the chip's critical path with a little extra delay added, so it starts to fail at a lower frequency than the real logic does. In each control interval the governor waits for the clock to settle after the last change. It then launches a toggling test value into the replica and, one cycle later, compares the captured value against the value it launched.

A clean result moves the code one step up. A mismatch moves it one step down. Because of this the code never rests: it keeps probing upward and settles into a one-step oscillation just under the replica's failure point. When conditions improve, for example when the die cools, the failure point moves up and the governor follows it without any command. Programmable limits bound the code. Two status flags report when the code is pinned at either limit.

Top module: `replica_clock_governor`

## Requirements
- R1: While reset is asserted, and right after it is released, `freqCode` equals `cfgMin`, `replicaLaunch` is 0, and both status flags are 0.
- R2: Each control interval toggles `replicaLaunch` exactly once. Consecutive toggles are `cfgSettle`+3 cycles apart. One cycle after a toggle, `replicaCapture` is compared with the new `replicaLaunch` level, and any difference counts as an error.
- R3: After every change of `freqCode`, `replicaLaunch` holds its level and toggles again exactly `cfgSettle`+2 cycles after the change.
- R4: A comparison with no error raises `freqCode` by exactly 1 in the cycle after the comparison, unless the code already equals `cfgMax`.
- R5: A comparison with an error lowers `freqCode` by exactly 1 in the cycle after the comparison, unless the code already equals `cfgMin`.
- R6: `freqCode` always stays within [`cfgMin`, `cfgMax`] and changes by at most 1 per cycle.
- R7: `atUpper` goes to 1 when a comparison passes while the code equals `cfgMax`, and the code then stays at `cfgMax`. It returns to 0 as soon as the code leaves `cfgMax`.
- R8: `atLowerFail` goes to 1 when a comparison fails while the code equals `cfgMin`, and the code then stays at `cfgMin`. It returns to 0 on the next passing comparison.
- R9: Suppose a replica passes for codes up to T and fails above T, with `cfgMin` ≤ T < `cfgMax`. The code then ends up alternating between T and T+1. When T changes, up or down, the code follows to the new pair on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMin | input | CODE_W | Lowest permitted frequency code; loaded at reset |
| cfgMax | input | CODE_W | Highest permitted frequency code |
| cfgSettle | input | CNT_W | Settle cycles after a code change before the next test |
| replicaCapture | input | 1 | Value captured at the end of the replica path |
| replicaLaunch | output | 1 | Toggling test value driven into the replica path |
| freqCode | output | CODE_W | Frequency code to the clock generator |
| atUpper | output | 1 | Code is held at `cfgMax` after a pass |
| atLowerFail | output | 1 | Code is held at `cfgMin` while errors persist |

## Verification
Some properties are checked on every cycle. The code must stay inside its limits and never move by more than one step. Each upward step must follow a matching capture, and each downward step must follow a mismatch. A code change must never coincide with a launch toggle, and the flags may only be set while the code sits at the matching limit. Other behaviour shows up only in the bench's scenarios: the exact settle and interval spacing, convergence to the two-code oscillation around a modelled failure threshold, and re-tracking after that threshold moves up or down.

// File: rtl/gov_pkg.sv
package gov_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE  = 2'd0,
    ST_LAUNCH  = 2'd1,
    ST_COMPARE = 2'd2
  } govState_t;

  typedef struct packed {
    logic cntInc;   // advance the settle counter
    logic launch;   // toggle the replica test value
    logic judge;    // compare capture, step the code, clear counter
  } govStrobe_t;

endpackage

// File: rtl/gov_ctrl.sv
module gov_ctrl
  import gov_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       settleDone,
  output govStrobe_t strobe
);

  govState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SETTLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_SETTLE: begin
        if (settleDone) stateNext = ST_LAUNCH;
        else            strobe.cntInc = 1'b1;
      end
      ST_LAUNCH: begin
        strobe.launch = 1'b1;
        stateNext     = ST_COMPARE;
      end
      ST_COMPARE: begin
        strobe.judge = 1'b1;
        stateNext    = ST_SETTLE;
      end
      default: stateNext = ST_SETTLE;
    endcase
  end

endmodule

// File: rtl/gov_datapath.sv
module gov_datapath
  import gov_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  govStrobe_t        strobe,
  input  logic [CODE_W-1:0] cfgMin,
  input  logic [CODE_W-1:0] cfgMax,
  input  logic [CNT_W-1:0]  cfgSettle,
  input  logic              replicaCapture,
  output logic              settleDone,
  output logic              replicaLaunch,
  output logic [CODE_W-1:0] freqCode,
  output logic              atUpper,
  output logic              atLowerFail
);

  localparam logic [CODE_W-1:0] CODE_STEP = CODE_W'(1);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(1);

  logic [CNT_W-1:0] settleCnt;
  logic             mismatch;
  logic             canRise;
  logic             canFall;

  assign settleDone = (settleCnt >= cfgSettle);
  assign mismatch   = (replicaCapture != replicaLaunch);
  assign canRise    = (freqCode < cfgMax);
  assign canFall    = (freqCode > cfgMin);

  always_ff @(posedge clk) begin
    if (!rstN)              settleCnt <= '0;
    else if (strobe.judge)  settleCnt <= '0;
    else if (strobe.cntInc) settleCnt <= settleCnt + CNT_STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              replicaLaunch <= 1'b0;
    else if (strobe.launch) replicaLaunch <= ~replicaLaunch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqCode    <= cfgMin;
      atUpper     <= 1'b0;
      atLowerFail <= 1'b0;
    end else if (strobe.judge) begin
      if (mismatch) begin
        atUpper <= 1'b0;
        if (canFall) begin
          freqCode    <= freqCode - CODE_STEP;
          atLowerFail <= 1'b0;
        end else begin
          atLowerFail <= 1'b1;
        end
      end else begin
        atLowerFail <= 1'b0;
        if (canRise) begin
          freqCode <= freqCode + CODE_STEP;
          atUpper  <= 1'b0;
        end else begin
          atUpper <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/replica_clock_governor.sv
module replica_clock_governor
  import gov_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cfgMin,
  input  logic [CODE_W-1:0] cfgMax,
  input  logic [CNT_W-1:0]  cfgSettle,
  input  logic              replicaCapture,
  output logic              replicaLaunch,
  output logic [CODE_W-1:0] freqCode,
  output logic              atUpper,
  output logic              atLowerFail
);

  govStrobe_t strobe;
  logic       settleDone;

  gov_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .settleDone (settleDone),
    .strobe     (strobe)
  );

  gov_datapath #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .cfgMin         (cfgMin),
    .cfgMax         (cfgMax),
    .cfgSettle      (cfgSettle),
    .replicaCapture (replicaCapture),
    .settleDone     (settleDone),
    .replicaLaunch  (replicaLaunch),
    .freqCode       (freqCode),
    .atUpper        (atUpper),
    .atLowerFail    (atLowerFail)
  );

endmodule

// File: rtl/gov_checker.sv
module gov_checker #(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] cfgMin,
  input logic [CODE_W-1:0] cfgMax,
  input logic [CNT_W-1:0]  cfgSettle,
  input logic              replicaCapture,
  input logic              replicaLaunch,
  input logic [CODE_W-1:0] freqCode,
  input logic              atUpper,
  input logic              atLowerFail
);

  // R6
  code_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode >= cfgMin) && (freqCode <= cfgMax));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode == $past(freqCode)) || (freqCode == $past(freqCode) + CODE_W'(1)) ||
    (freqCode == $past(freqCode) - CODE_W'(1)));

  // R4
  rise_after_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode > $past(freqCode)) |-> $past(replicaCapture == replicaLaunch));

  // R5
  fall_after_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode < $past(freqCode)) |-> $past(replicaCapture != replicaLaunch));

  // R3
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freqCode != $past(freqCode)) |-> ($stable(replicaLaunch) ##1 $stable(replicaLaunch)));

  // R7
  upper_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    atUpper |-> (freqCode == cfgMax));

  // R8
  lower_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    atLowerFail |-> (freqCode == cfgMin));

  // R7 R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(atUpper && atLowerFail));

endmodule

bind replica_clock_governor gov_checker #(
  .CODE_W (CODE_W),
  .CNT_W  (CNT_W)
) u_gov_chk (
  .clk            (clk),
  .rstN           (rstN),
  .cfgMin         (cfgMin),
  .cfgMax         (cfgMax),
  .cfgSettle      (cfgSettle),
  .replicaCapture (replicaCapture),
  .replicaLaunch  (replicaLaunch),
  .freqCode       (freqCode),
  .atUpper        (atUpper),
  .atLowerFail    (atLowerFail)
);

// File: tb/replica_clock_governor_test.sv
module replica_clock_governor_test;

  localparam int CODE_W = 6;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CODE_W-1:0] cfgMin = 6'd4;
  logic [CODE_W-1:0] cfgMax = 6'd40;
  logic [CNT_W-1:0]  cfgSettle = 8'd3;
  logic [CODE_W-1:0] thr = 6'd63;
  logic              replicaCapture;
  logic              replicaLaunch;
  logic [CODE_W-1:0] freqCode;
  logic              atUpper;
  logic              atLowerFail;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // replica model: fails (inverted capture) above threshold code
  assign replicaCapture = (freqCode > thr) ? ~replicaLaunch : replicaLaunch;

  replica_clock_governor #(.CODE_W(CODE_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .cfgMin(cfgMin), .cfgMax(cfgMax),
    .cfgSettle(cfgSettle), .replicaCapture(replicaCapture),
    .replicaLaunch(replicaLaunch), .freqCode(freqCode),
    .atUpper(atUpper), .atLowerFail(atLowerFail)
  );

  function automatic bit inBand(int code, int t);
    return (code == t) || (code == t + 1);
  endfunction

  function automatic int roundLen(int s);
    return s + 3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic doReset(int mn, int mx, int st, int t);
    @(negedge clk);
    rstN = 1'b0;
    cfgMin = CODE_W'(mn); cfgMax = CODE_W'(mx); cfgSettle = CNT_W'(st); thr = CODE_W'(t);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitLaunch(output int n);
    logic prev = replicaLaunch;
    n = 0;
    do begin @(negedge clk); n++; end while (replicaLaunch == prev && n < 2000);
  endtask

  task automatic waitCode(output int n);
    logic [CODE_W-1:0] prev = freqCode;
    n = 0;
    do begin @(negedge clk); n++; end while (freqCode == prev && n < 2000);
  endtask

  task automatic checkBand(int t, string req);
    bit sawLo = 0, sawHi = 0;
    for (int i = 0; i < 4 * roundLen(int'(cfgSettle)); i++) begin
      @(negedge clk);
      if (freqCode == CODE_W'(t)) sawLo = 1;
      if (freqCode == CODE_W'(t + 1)) sawHi = 1;
      if (!inBand(int'(freqCode), t)) begin
        check(0, req, int'(freqCode), t);
        return;
      end
    end
    check(sawLo && sawHi, req, int'(sawLo) * 2 + int'(sawHi), 3);
  endtask

  initial begin
    int n, g, c, t, st, mn, mx, wait_cycles;
    void'($urandom(32'd1234));

    // R1 reset state, during and just after reset
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(freqCode == 6'd4 && !replicaLaunch && !atUpper && !atLowerFail,
          "R1", int'(freqCode), 4);
    rstN = 1'b1;
    @(negedge clk);
    check(freqCode == 6'd4 && !atUpper && !atLowerFail, "R1", int'(freqCode), 4);

    // R3 settle spacing after a code change, R2 interval spacing
    waitCode(n);
    waitLaunch(g);
    check(g == 3 + 2, "R3", g, 5);
    waitLaunch(n);
    waitLaunch(g);
    check(g == roundLen(3), "R2", g, roundLen(3));

    // R4 pass steps up by one the cycle after the comparison
    waitLaunch(n);
    c = int'(freqCode);
    @(negedge clk);
    check(int'(freqCode) == c + 1, "R4", int'(freqCode), c + 1);

    // R5 errors step down by one
    waitCode(n);
    thr = 6'd0;
    waitLaunch(n);
    c = int'(freqCode);
    @(negedge clk);
    check(int'(freqCode) == c - 1, "R5", int'(freqCode), c - 1);

    // R8 held at minimum while errors persist, cleared by a pass
    doReset(4, 40, 2, 1);
    repeat (4 * roundLen(2)) @(negedge clk);
    check(freqCode == 6'd4 && atLowerFail, "R8", int'(atLowerFail), 1);
    thr = 6'd63;
    waitLaunch(n);
    @(negedge clk);
    check(!atLowerFail && freqCode == 6'd5, "R8", int'(atLowerFail), 0);

    // R7 held at maximum after a pass, cleared once the code leaves it
    doReset(4, 12, 1, 63);
    repeat (12 * roundLen(1)) @(negedge clk);
    check(freqCode == 6'd12 && atUpper, "R7", int'(freqCode), 12);
    thr = 6'd8;
    waitCode(n);
    check(!atUpper && freqCode == 6'd11, "R7", int'(atUpper), 0);
    // R6 code stays inside limits while it settles back down
    repeat (8 * roundLen(1)) @(negedge clk);
    check(freqCode >= 6'd4 && freqCode <= 6'd12, "R6", int'(freqCode), 9);

    // R9 random thresholds and settle counts, then drift up and down
    for (int k = 0; k < 6; k++) begin
      mn = 2 + int'($urandom_range(0, 6));
      mx = mn + 10 + int'($urandom_range(0, 30));
      if (mx > 62) mx = 62;
      st = int'($urandom_range(0, 7));
      t  = mn + 1 + int'($urandom_range(0, mx - mn - 4));
      doReset(mn, mx, st, t);
      wait_cycles = (mx - mn + 3) * roundLen(st);
      repeat (wait_cycles) @(negedge clk);
      checkBand(t, "R9");
      // cooler die: threshold rises, code must follow upward
      t = t + 1 + int'($urandom_range(0, 2));
      if (t > mx - 1) t = mx - 1;
      thr = CODE_W'(t);
      repeat (6 * roundLen(st)) @(negedge clk);
      checkBand(t, "R9");
      // hotter die: threshold falls, code must follow downward
      t = mn + int'($urandom_range(0, 2));
      thr = CODE_W'(t);
      repeat (wait_cycles) @(negedge clk);
      checkBand(t, "R9");
    end

    // R3 settle spacing with a longer settle count
    doReset(4, 40, 9, 63);
    waitCode(n);
    waitLaunch(g);
    check(g == 9 + 2, "R3", g, 11);

    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finishRun();
  end

endmodule